// File: doc/BRIEF.md
# Quadrature Position Counter

This block keeps a 16-bit signed-agnostic position count for a rotary or linear encoder that delivers two phase signals in quadrature. Every valid transition of either phase moves the count by one (four counts per phase period), up or down according to which phase leads. Phase and index pins are brought into the clock domain with two-flop synchronizers before any decision is made on them.

Counting runs only while the run enable is high. A hold-mode control decides what dropping the enable does. With hold mode off, the count is zeroed, and the next rising of the enable loads a preset value. With hold mode on, the count freezes and resumes from the frozen value. The count is always visible on an output port, so reading it never disturbs it. A two-bit select picks an automatic clear source: none, equality with a compare value, a high index pin, or a high index pin together with a chosen phase state. A one-cycle flag reports when the count reaches the compare value.

Top module: `enc_pos_counter`

## Requirements
- R1: While reset is asserted and after it is released, `count` is 0x0000 and `cmp_hit` is 0.
- R2: Phase state is the pair {A,B}. The forward order is 00, 10, 11, 01, 00. A one-step move forward adds 1 and a one-step move backward subtracts 1, three clock edges after the pin change. A change of both phases at once leaves the count unchanged.
- R3: The count wraps modulo 2^16: 0xFFFF plus one step gives 0x0000, and 0x0000 minus one step gives 0xFFFF.
- R4: With `hold_mode`=0, the clock edge where `run_en` is seen low after being high sets `count` to 0x0000.
- R5: After an R4 clear, and on the first enable after reset, the first clock edge with `run_en` high loads `preset_val` into `count`, and counting starts on the edge after that.
- R6: With `hold_mode`=1, dropping `run_en` keeps `count` unchanged, and raising it again resumes from that value with no load.
- R7: While `run_en` is low, phase transitions do not change `count`.
- R8: `clr_sel`=00 gives no automatic clear. `clr_sel`=01 clears the count to 0 on the edge where a running count equals `cmp_val`. The clear takes priority over a step.
- R9: `clr_sel`=10 holds the running count at 0 while the synchronized index pin is high.
- R10: `clr_sel`=11 clears the running count only while the synchronized index is high and the synchronized {A,B} equals `clr_lvl` (A in bit 1, B in bit 0).
- R11: `cmp_hit` is high for exactly one cycle while running, in the first cycle in which `count` equals `cmp_val` after a cycle in which it differed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Counting enable |
| hold_mode | input | 1 | 1: keep value when disabled; 0: zero and reload |
| preset_val | input | 16 | Value loaded on re-enable after a zeroing |
| clr_sel | input | 2 | Automatic clear source select |
| clr_lvl | input | 2 | {A,B} phase state that qualifies the index clear in mode 11 |
| cmp_val | input | 16 | Compare value |
| ph_a | input | 1 | Encoder phase A pin |
| ph_b | input | 1 | Encoder phase B pin |
| idx_in | input | 1 | Index / clear pin |
| count | output | 16 | Current position count |
| cmp_hit | output | 1 | One-cycle compare-match pulse |

## Verification
The hardest case is a clear in mode 11 that lands on the same edge as a valid step into the qualifying phase state. The bench raises the index while the phases sit two states away from `clr_lvl`, so no clear happens. It then walks forward one state at a time and shows that the step into the matching state ends at zero and not at the incremented value. Wrap-around in both directions is reached by loading presets near the ends of the range through the zero-then-reload sequence.

// File: rtl/enc_pos_counter.sv
module enc_pos_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          hold_mode,
  input  logic [CW-1:0] preset_val,
  input  logic [1:0]    clr_sel,
  input  logic [1:0]    clr_lvl,
  input  logic [CW-1:0] cmp_val,
  input  logic          ph_a,
  input  logic          ph_b,
  input  logic          idx_in,
  output logic [CW-1:0] count,
  output logic          cmp_hit
);

  logic [1:0] a_sy, b_sy, i_sy;
  logic [1:0] ab, ab_q, pos_n, pos_q, diff;
  logic       en_q, load_pend, eq_seen;
  logic       running, eq, step_up, step_dn, clr_now;

  assign ab      = {a_sy[1], b_sy[1]};
  assign pos_n   = {ab[0], ab[1] ^ ab[0]};
  assign pos_q   = {ab_q[0], ab_q[1] ^ ab_q[0]};
  assign diff    = pos_n - pos_q;
  assign step_up = (diff == 2'd1);
  assign step_dn = (diff == 2'd3);
  assign running = run_en & en_q;
  assign eq      = (count == cmp_val);
  assign cmp_hit = running & eq & ~eq_seen;

  always_comb begin
    unique case (clr_sel)
      2'b00:   clr_now = 1'b0;
      2'b01:   clr_now = eq;
      2'b10:   clr_now = i_sy[1];
      default: clr_now = i_sy[1] & (ab == clr_lvl);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_sy <= '0;
      b_sy <= '0;
      i_sy <= '0;
      ab_q <= '0;
    end else begin
      a_sy <= {a_sy[0], ph_a};
      b_sy <= {b_sy[0], ph_b};
      i_sy <= {i_sy[0], idx_in};
      ab_q <= ab;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '0;
      en_q      <= 1'b0;
      load_pend <= 1'b1;
      eq_seen   <= 1'b0;
    end else begin
      en_q    <= run_en;
      eq_seen <= eq;
      if (en_q && !run_en) begin
        if (!hold_mode) begin
          count     <= '0;
          load_pend <= 1'b1;
        end
      end else if (run_en && !en_q) begin
        if (load_pend) count <= preset_val;
        load_pend <= 1'b0;
      end else if (running) begin
        if (clr_now)      count <= '0;
        else if (step_up) count <= count + 1'b1;
        else if (step_dn) count <= count - 1'b1;
      end
    end
  end

endmodule

module enc_pos_counter_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_en,
  input logic          hold_mode,
  input logic          en_q,
  input logic          load_pend,
  input logic [CW-1:0] preset_val,
  input logic [CW-1:0] count,
  input logic          cmp_hit
);

  p_zero_on_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !run_en && !hold_mode) |=> (count == '0));

  p_load_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !en_q && load_pend) |=> (count == $past(preset_val)));

  p_freeze_on_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !run_en && hold_mode) |=> $stable(count));

  p_idle_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !en_q) |=> $stable(count));

  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && en_q) |=> (count == $past(count) || count == $past(count) + 1'b1 ||
                          count == $past(count) - 1'b1 || count == '0));

  p_hit_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |=> !cmp_hit);

endmodule

bind enc_pos_counter enc_pos_counter_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .hold_mode(hold_mode),
  .en_q(en_q), .load_pend(load_pend), .preset_val(preset_val),
  .count(count), .cmp_hit(cmp_hit)
);

// File: tb/enc_pos_counter_bench.sv
module enc_pos_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0, hold_mode = 1'b0;
  logic [15:0] preset_val = '0, cmp_val = 16'h0100;
  logic [1:0]  clr_sel = 2'b00, clr_lvl = 2'b00;
  logic        ph_a = 1'b0, ph_b = 1'b0, idx_in = 1'b0;
  logic [15:0] count;
  logic        cmp_hit;
  int total = 0, bad = 0, hits = 0;
  int pos = 0;
  logic [15:0] exp_c;

  always #10 clk = ~clk;

  enc_pos_counter u_enc_pos_counter (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .hold_mode(hold_mode),
    .preset_val(preset_val), .clr_sel(clr_sel), .clr_lvl(clr_lvl),
    .cmp_val(cmp_val), .ph_a(ph_a), .ph_b(ph_b), .idx_in(idx_in),
    .count(count), .cmp_hit(cmp_hit)
  );

  always @(negedge clk) if (rst_n && cmp_hit) hits++;

  task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put_pos(input int p);
    pos = p & 3;
    ph_a = (pos == 1) || (pos == 2);
    ph_b = (pos >= 2);
  endtask

  task automatic step(input int dir, input int n);
    for (int i = 0; i < n; i++) begin
      put_pos(pos + dir);
      settle(4);
    end
  endtask

  task automatic reenable_with(input logic [15:0] pv);
    hold_mode = 1'b0; run_en = 1'b0; settle(2);
    preset_val = pv; run_en = 1'b1; settle(2);
  endtask

  task automatic t_reset;
    chk("R1 count", count, 16'h0000);
    chk("R1 hit", {15'd0, cmp_hit}, 16'h0000);
  endtask

  task automatic t_decode;
    preset_val = 16'h1234; run_en = 1'b1; settle(2);
    chk("R5 first load", count, 16'h1234);
    step(1, 5);  chk("R2 forward", count, 16'h1239);
    step(-1, 3); chk("R2 backward", count, 16'h1236);
    put_pos(pos + 2); settle(5);
    chk("R2 double change ignored", count, 16'h1236);
    step(1, 1); chk("R2 after double", count, 16'h1237);
  endtask

  task automatic t_drop_zero;
    run_en = 1'b0; settle(2);
    chk("R4 zero on drop", count, 16'h0000);
    step(1, 3); chk("R7 idle ignored", count, 16'h0000);
    preset_val = 16'h0002; run_en = 1'b1; settle(2);
    chk("R5 reload", count, 16'h0002);
  endtask

  task automatic t_wrap;
    step(-1, 3); chk("R3 underflow", count, 16'hFFFF);
    step(1, 1);  chk("R3 back to zero", count, 16'h0000);
    reenable_with(16'hFFFE);
    step(1, 3);  chk("R3 overflow", count, 16'h0001);
  endtask

  task automatic t_hold;
    reenable_with(16'h0000);
    hold_mode = 1'b1;
    step(1, 5); chk("R6 pre", count, 16'h0005);
    run_en = 1'b0; settle(3); chk("R6 frozen", count, 16'h0005);
    step(1, 2); chk("R7 held idle", count, 16'h0005);
    preset_val = 16'h7777; run_en = 1'b1; settle(2);
    chk("R6 no load", count, 16'h0005);
    step(1, 1); chk("R6 resume", count, 16'h0006);
  endtask

  task automatic t_compare;
    int h0;
    cmp_val = 16'h0008;
    step(1, 1); chk("R11 pre", count, 16'h0007);
    h0 = hits;
    step(1, 1); chk("R8 mode00 no clear", count, 16'h0008);
    chk("R11 one pulse", 16'(hits - h0), 16'h0001);
    settle(3);
    chk("R11 pulse ended", 16'(hits - h0), 16'h0001);
    cmp_val = 16'h000A; clr_sel = 2'b01;
    step(1, 1);
    h0 = hits;
    step(1, 1); chk("R8 compare clear", count, 16'h0000);
    chk("R11 pulse on clear", 16'(hits - h0), 16'h0001);
  endtask

  task automatic t_index;
    cmp_val = 16'h0100;
    clr_sel = 2'b00; idx_in = 1'b1; step(1, 2);
    chk("R8 mode00 index ignored", count, 16'h0002);
    clr_sel = 2'b10; settle(2);
    chk("R9 index clear", count, 16'h0000);
    step(1, 2); chk("R9 held at zero", count, 16'h0000);
    idx_in = 1'b0; settle(4);
    step(1, 3); chk("R9 released", count, 16'h0003);
  endtask

  task automatic t_qualified;
    int tgt;
    clr_sel = 2'b11;
    tgt = (pos + 2) & 3;
    clr_lvl = {(tgt == 1) || (tgt == 2), tgt >= 2};
    idx_in = 1'b1; settle(5);
    chk("R10 level mismatch", count, 16'h0003);
    step(1, 1); chk("R10 step no match", count, 16'h0004);
    step(1, 1); chk("R10 clear beats step", count, 16'h0000);
    idx_in = 1'b0; settle(4);
    step(1, 2); chk("R10 released", count, 16'h0002);
  endtask

  initial begin
    settle(3);
    t_reset();
    rst_n = 1'b1; settle(2);
    t_reset();
    t_decode();
    t_drop_zero();
    t_wrap();
    t_hold();
    t_compare();
    t_index();
    t_qualified();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule